// File: doc/BRIEF.md
# CAN Transmit Buffer Priority Selector

This block decides which of a small set of CAN transmit message buffers is sent next. Each buffer owns a local priority register and an empty flag. The host writes priority values through a simple write port. It moves a buffer to the pending state by writing a one to that buffer's bit on the transmit-request input. A pending buffer has its empty flag clear.

The protocol engine raises a one-cycle strobe just before it sends a Start of Frame. On that strobe the block compares only the pending buffers. The numerically smallest priority value wins, and a tie goes to the lower buffer index. The block latches the winning index and holds it, with a valid flag, until the engine reports that the transmission completed or was aborted. On completion, the winning buffer's empty flag is set again. On abort, the buffer stays pending and competes again at the next Start of Frame.

A two-state machine controls the selection:
- **IDLE**: no grant is held. The transition *launch* (to GRANT) occurs on a Start-of-Frame strobe while at least one buffer is pending. A strobe with nothing pending keeps the machine in IDLE.
- **GRANT**: a winner is held. The transition *release* (to IDLE) occurs on a completion or abort pulse. Every other input keeps the machine in GRANT.

Top module: `can_tx_prio_sel`

## Requirements
- R1: After reset, every priority register reads as 0x00, every empty flag is set, and grant_valid is low.
- R2: A one on bit i of tx_req clears buffer i's empty flag at the next clock edge. A zero bit leaves that buffer's flag unchanged.
- R3: When sof_request is high while no grant is held and at least one buffer is pending, grant_valid is high from the next cycle. grant_idx then holds the index of the pending buffer whose priority value is numerically smallest. Both inputs are evaluated from the register state before that edge.
- R4: When several pending buffers share the smallest priority value, the lowest index among them is granted.
- R5: Buffers whose empty flag is set never win. A sof_request with no buffer pending leaves grant_valid low.
- R6: While grant_valid is high, grant_idx does not change until tx_done or tx_abort. A sof_request or a priority write during a grant has no effect on the current grant, but a priority write is used at the next selection.
- R7: tx_done while a grant is held sets the winning buffer's empty flag and drops grant_valid on the next cycle. tx_done without a grant has no effect.
- R8: tx_abort while a grant is held drops grant_valid on the next cycle and leaves the winning buffer pending.
- R9: If tx_req sets the winning buffer's bit in the same cycle as tx_done, that buffer remains pending.
- R10: If tx_done and tx_abort arrive in the same cycle during a grant, the completion behaviour of R7 applies.
- R11: A priority write whose prio_sel is not below the buffer count changes no priority register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_we | input | 1 | Priority register write enable |
| prio_sel | input | IDX_W | Buffer index for the priority write |
| prio_wdata | input | PRIO_W | Priority value to write (smaller value means more urgent) |
| tx_req | input | NUM_BUF | Per-buffer transmit request. A one marks that buffer pending. |
| sof_request | input | 1 | One-cycle strobe before a Start of Frame |
| tx_done | input | 1 | The granted transmission completed |
| tx_abort | input | 1 | The granted transmission was abandoned |
| grant_valid | output | 1 | A winning buffer is held |
| grant_idx | output | IDX_W | Index of the held winning buffer |
| buf_empty | output | NUM_BUF | Per-buffer empty flags (clear means pending) |

## Verification
The bench builds the block with its default values: three buffers and 8-bit priorities, giving a 2-bit index.

The two-bit selector has one code, 3, that maps to no buffer, so the bench can exercise the ignored-write case of R11. Random priorities are drawn mostly from 0 to 3, so ties among pending buffers happen often. Other draws cover the full 8-bit range, including 0x00 and 0xFF.

Directed sequences reach the cases that random stimulus rarely lines up:
- a request in the same cycle as a completion;
- completion and abort in the same cycle;
- priority writes during a held grant.

// File: rtl/can_tx_prio_pkg.sv
package can_tx_prio_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } sel_state_t;

endpackage

// File: rtl/can_tx_prio_regs.sv
module can_tx_prio_regs #(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prio_we,
    input  logic [IDX_W-1:0]          prio_sel,
    input  logic [PRIO_W-1:0]         prio_wdata,
    input  logic [NUM_BUF-1:0]        tx_req,
    input  logic                      release_en,
    input  logic [IDX_W-1:0]          release_idx,
    output logic [NUM_BUF*PRIO_W-1:0] prio_flat,
    output logic [NUM_BUF-1:0]        empty
);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        logic [PRIO_W-1:0] prio_q;
        logic              empty_q;

        // Priority storage: a write only lands on its own index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
            end else if (prio_we && (prio_sel == IDX_W'(i))) begin
                prio_q <= prio_wdata;
            end
        end

        // A host request beats a completion on the same buffer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                empty_q <= 1'b1;
            end else if (tx_req[i]) begin
                empty_q <= 1'b0;
            end else if (release_en && (release_idx == IDX_W'(i))) begin
                empty_q <= 1'b1;
            end
        end

        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
        assign empty[i]                      = empty_q;
    end

endmodule

// File: rtl/can_tx_prio_arb.sv
module can_tx_prio_arb #(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BUF*PRIO_W-1:0] prio_flat,
    input  logic [NUM_BUF-1:0]        empty,
    output logic                      any_pending,
    output logic [IDX_W-1:0]          win_idx
);

    logic [PRIO_W-1:0] best_prio;

    // Ascending scan: a strict compare keeps the earlier index on a tie.
    always_comb begin
        any_pending = 1'b0;
        win_idx     = '0;
        best_prio   = '1;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (!empty[i] &&
                (!any_pending || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
                any_pending = 1'b1;
                best_prio   = prio_flat[i*PRIO_W +: PRIO_W];
                win_idx     = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_tx_prio_fsm.sv
module can_tx_prio_fsm
    import can_tx_prio_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_request,
    input  logic             tx_done,
    input  logic             tx_abort,
    input  logic             any_pending,
    input  logic [IDX_W-1:0] win_idx,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx,
    output logic             release_en
);

    sel_state_t state_q;
    sel_state_t state_d;
    logic       launch;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_request && any_pending) begin
                    launch  = 1'b1;
                    state_d = ST_GRANT;
                end
            end
            ST_GRANT: begin
                if (tx_done || tx_abort) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Winner latch: captured only on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_idx <= '0;
        end else if (launch) begin
            grant_idx <= win_idx;
        end
    end

    // Outputs.
    always_comb begin
        grant_valid = 1'b0;
        release_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                grant_valid = 1'b0;
            end
            ST_GRANT: begin
                grant_valid = 1'b1;
                release_en  = tx_done;
            end
            default: begin
                grant_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel #(
    parameter int  NUM_BUF = 3,
    parameter int  PRIO_W  = 8,
    localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prio_we,
    input  logic [IDX_W-1:0]   prio_sel,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic [NUM_BUF-1:0] tx_req,
    input  logic               sof_request,
    input  logic               tx_done,
    input  logic               tx_abort,
    output logic               grant_valid,
    output logic [IDX_W-1:0]   grant_idx,
    output logic [NUM_BUF-1:0] buf_empty
);

    logic [NUM_BUF*PRIO_W-1:0] prio_flat;
    logic                      any_pending;
    logic [IDX_W-1:0]          win_idx;
    logic                      release_en;

    can_tx_prio_regs #(
        .NUM_BUF(NUM_BUF),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .prio_sel   (prio_sel),
        .prio_wdata (prio_wdata),
        .tx_req     (tx_req),
        .release_en (release_en),
        .release_idx(grant_idx),
        .prio_flat  (prio_flat),
        .empty      (buf_empty)
    );

    can_tx_prio_arb #(
        .NUM_BUF(NUM_BUF),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_arb (
        .prio_flat  (prio_flat),
        .empty      (buf_empty),
        .any_pending(any_pending),
        .win_idx    (win_idx)
    );

    can_tx_prio_fsm #(
        .IDX_W(IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_request(sof_request),
        .tx_done    (tx_done),
        .tx_abort   (tx_abort),
        .any_pending(any_pending),
        .win_idx    (win_idx),
        .grant_valid(grant_valid),
        .grant_idx  (grant_idx),
        .release_en (release_en)
    );

endmodule

// File: rtl/can_tx_prio_chk.sv
module can_tx_prio_chk #(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] tx_req,
    input logic               sof_request,
    input logic               tx_done,
    input logic               tx_abort,
    input logic               grant_valid,
    input logic [IDX_W-1:0]   grant_idx,
    input logic [NUM_BUF-1:0] buf_empty
);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_req
        // R2
        a_r2_req_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
            tx_req[i] |=> !buf_empty[i]);
    end

    a_r3_launch_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && sof_request && !(&buf_empty)) |=> grant_valid);

    a_r3_winner_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !buf_empty[grant_idx]);

    a_r5_no_grant_when_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (&buf_empty)) |=> !grant_valid);

    a_r6_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !tx_done && !tx_abort) |=> (grant_valid && $stable(grant_idx)));

    a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && tx_done && !tx_req[grant_idx])
            |=> (!grant_valid && buf_empty[$past(grant_idx)]));

    a_r8_abort_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && tx_abort && !tx_done)
            |=> (!grant_valid && !buf_empty[$past(grant_idx)]));

    a_r9_req_beats_done: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && tx_done && tx_req[grant_idx])
            |=> !buf_empty[$past(grant_idx)]);

endmodule

bind can_tx_prio_sel can_tx_prio_chk #(
    .NUM_BUF(NUM_BUF),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .sof_request(sof_request),
    .tx_done    (tx_done),
    .tx_abort   (tx_abort),
    .grant_valid(grant_valid),
    .grant_idx  (grant_idx),
    .buf_empty  (buf_empty)
);

// File: tb/tb_can_tx_prio_sel.sv
module tb_can_tx_prio_sel;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_BUF    = 3;
    localparam int PRIO_W     = 8;
    localparam int IDX_W      = 2;
    localparam int RAND_CYCLES = 4000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               prio_we;
    logic [IDX_W-1:0]   prio_sel;
    logic [PRIO_W-1:0]  prio_wdata;
    logic [NUM_BUF-1:0] tx_req;
    logic               sof_request;
    logic               tx_done;
    logic               tx_abort;
    logic               grant_valid;
    logic [IDX_W-1:0]   grant_idx;
    logic [NUM_BUF-1:0] buf_empty;

    // Reference state
    logic [PRIO_W-1:0]  m_prio [NUM_BUF];
    logic [NUM_BUF-1:0] m_empty;
    logic               m_gv;
    logic [IDX_W-1:0]   m_gi;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_prio_sel #(
        .NUM_BUF(NUM_BUF),
        .PRIO_W (PRIO_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .prio_sel   (prio_sel),
        .prio_wdata (prio_wdata),
        .tx_req     (tx_req),
        .sof_request(sof_request),
        .tx_done    (tx_done),
        .tx_abort   (tx_abort),
        .grant_valid(grant_valid),
        .grant_idx  (grant_idx),
        .buf_empty  (buf_empty)
    );

    // Winner by rule: smallest value among pending buffers, lowest index on ties.
    function automatic logic [IDX_W-1:0] ref_winner();
        logic [IDX_W-1:0] w = '0;
        bit found = 1'b0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (!m_empty[i]) begin
                if (!found || (m_prio[i] < m_prio[w])) begin
                    w = IDX_W'(i);
                end
                found = 1'b1;
            end
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        prio_we     = 1'b0;
        prio_sel    = '0;
        prio_wdata  = '0;
        tx_req      = '0;
        sof_request = 1'b0;
        tx_done     = 1'b0;
        tx_abort    = 1'b0;
    endtask

    // Apply the driven inputs for one edge, advance the reference, compare.
    task automatic tick(input string req);
        logic [NUM_BUF-1:0] nxt_empty;
        bit done_eff;
        bit abort_eff;
        @(posedge clk);
        done_eff  = m_gv && tx_done;
        abort_eff = m_gv && tx_abort && !tx_done;
        nxt_empty = m_empty;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (tx_req[i]) nxt_empty[i] = 1'b0;
            else if (done_eff && (m_gi == IDX_W'(i))) nxt_empty[i] = 1'b1;
        end
        if (!m_gv && sof_request && !(&m_empty)) begin
            m_gi = ref_winner();
            m_gv = 1'b1;
        end else if (done_eff || abort_eff) begin
            m_gv = 1'b0;
        end
        if (prio_we && (int'(prio_sel) < NUM_BUF)) m_prio[prio_sel] = prio_wdata;
        m_empty = nxt_empty;
        @(negedge clk);
        check(grant_valid == m_gv, req, "grant_valid", int'(grant_valid), int'(m_gv));
        if (m_gv)
            check(grant_idx == m_gi, req, "grant_idx", int'(grant_idx), int'(m_gi));
        check(buf_empty == m_empty, req, "buf_empty", int'(buf_empty), int'(m_empty));
        idle_inputs();
    endtask

    task automatic wr_prio(input int idx, input int val, input string req);
        prio_we    = 1'b1;
        prio_sel   = IDX_W'(idx);
        prio_wdata = PRIO_W'(val);
        tick(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 1'b0;
        for (int i = 0; i < NUM_BUF; i++) m_prio[i] = '0;
        m_empty = '1;
        m_gv    = 1'b0;
        m_gi    = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(grant_valid == 1'b0, "R1", "grant_valid", int'(grant_valid), 0);
        check(buf_empty == '1, "R1", "buf_empty", int'(buf_empty), 7);
        // R1: zero priorities with all requested -> index 0 wins the tie (R4)
        tx_req = 3'b111; tick("R2");
        sof_request = 1'b1; tick("R1");
        check(grant_idx == 0, "R1", "grant_idx zero prios", int'(grant_idx), 0);
        tx_done = 1'b1; tx_req = 3'b001; tick("R9");

        // R5: nothing pending except after clearing all
        tx_done = 1'b0;
        sof_request = 1'b1; tick("R3");
        tx_done = 1'b1; tick("R7");
        sof_request = 1'b1; tick("R3");
        tx_done = 1'b1; tick("R7");
        sof_request = 1'b1; tick("R3");
        tx_done = 1'b1; tick("R7");
        sof_request = 1'b1; tick("R5");
        check(grant_valid == 1'b0, "R5", "grant with none pending", int'(grant_valid), 0);
        tx_done = 1'b1; tick("R7");   // done without grant ignored

        // R11: write to out-of-range index
        wr_prio(3, 8'h11, "R11");
        wr_prio(0, 5, "R3");
        wr_prio(1, 3, "R4");
        wr_prio(2, 3, "R4");
        tx_req = 3'b111; tick("R2");
        sof_request = 1'b1; tick("R4");
        check(grant_idx == 1, "R4", "tie winner", int'(grant_idx), 1);

        // R6: priority write and sof during grant
        prio_we = 1'b1; prio_sel = 2; prio_wdata = 8'h00; sof_request = 1'b1; tick("R6");
        check(grant_idx == 1, "R6", "held index", int'(grant_idx), 1);
        tick("R6");

        // R8: abort keeps pending; new priority used next
        tx_abort = 1'b1; tick("R8");
        sof_request = 1'b1; tick("R6");
        check(grant_idx == 2, "R6", "write used at next selection", int'(grant_idx), 2);
        tx_done = 1'b1; tx_abort = 1'b1; tick("R10");
        check(buf_empty[2] == 1'b1, "R10", "done wins over abort", int'(buf_empty[2]), 1);

        // R9: request in the same cycle as completion
        sof_request = 1'b1; tick("R3");
        tx_done = 1'b1; tx_req = 3'b010; tick("R9");
        wr_prio(1, 8'hFF, "R3");
        sof_request = 1'b1; tick("R3");
        check(grant_idx == 0, "R3", "smallest value wins", int'(grant_idx), 0);
        tx_done = 1'b1; tick("R7");

        // Random phase
        for (int c = 0; c < RAND_CYCLES; c++) begin
            if ($urandom % 4 == 0) begin
                prio_we    = 1'b1;
                prio_sel   = IDX_W'($urandom % 4);
                prio_wdata = ($urandom % 3 != 0) ? PRIO_W'($urandom % 4) : PRIO_W'($urandom);
            end
            if ($urandom % 5 == 0) tx_req = NUM_BUF'($urandom);
            sof_request = ($urandom % 4 == 0);
            if (m_gv) begin
                case ($urandom % 6)
                    0: tx_done = 1'b1;
                    1: tx_abort = 1'b1;
                    2: begin tx_done = 1'b1; tx_abort = 1'b1; end
                    default: ;
                endcase
            end else if ($urandom % 8 == 0) begin
                tx_done = 1'b1;
            end
            tick("R3");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule